// File: doc/BRIEF.md
# Dual-Slot Integer Divide and Square-Root Unit

This block performs unsigned 32-bit integer division and unsigned 32-bit integer square root. Each operation is iterative and takes many cycles. The block has two independent iteration slots, so two operations can be in flight together. No slot is pipelined: once a slot takes an operation, it works only on that operation until the result has been handed out.

A producer offers an operation on the issue side. It presents an opcode, two operands and a tag. The operation is taken on any rising edge where the valid and ready signals are both high. Ready drops only while both slots are occupied. A new operation always goes into the lowest-numbered free slot.

The completion side raises a valid flag for one cycle per result. With that flag it gives the tag the operation was issued with, plus a quotient and a remainder. For a square root, the root appears in place of the quotient. Division and square root have different, fixed latencies.

Top module: `divSqrtPair`

## Requirements
- R1: With issueOp = 0 (divide) and a nonzero divisor issueB, the result has doneQuo = floor(issueA / issueB) and doneRem = issueA mod issueB, both unsigned.
- R2: A divide whose issueB is zero returns doneQuo = 32'hFFFFFFFF and doneRem = issueA. It completes on the normal divide latency.
- R3: With issueOp = 1 (square root), doneQuo[15:0] holds the largest r with r*r <= issueA. doneQuo[31:16] is zero, and doneRem = issueA - r*r.
- R4: A divide accepted on rising edge E shows its result, with doneValid high, in the cycle that follows edge E+18.
- R5: A square root accepted on rising edge E shows its result, with doneValid high, in the cycle that follows edge E+23.
- R6: issueReady is low exactly when both slots hold an operation that is still computing or whose result has not yet been reported. Two operations can be computing at the same time.
- R7: An accepted operation goes into slot 0 if slot 0 is free, and into slot 1 otherwise. Each slot is freed on the edge that ends the cycle in which its result is reported.
- R8: When both slots have a result waiting, slot 0 is reported first. Slot 1 is held and reported in the following cycle. Each report lasts exactly one cycle.
- R9: Each result carries on doneTag the issueTag value that came with its operation.
- R10: After reset, doneValid is low and issueReady is high.
- R11: An issueValid pulse on an edge where issueReady is low is ignored. It produces no result and does not change any result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | An operation is offered |
| issueOp | input | 1 | 0 = divide, 1 = square root |
| issueA | input | 32 | Dividend or radicand |
| issueB | input | 32 | Divisor (ignored for square root) |
| issueTag | input | 4 | Identifier returned with the result |
| issueReady | output | 1 | At least one slot is free |
| doneValid | output | 1 | A result is presented this cycle |
| doneTag | output | 4 | Tag of the presented result |
| doneQuo | output | 32 | Quotient, or root in the low 16 bits |
| doneRem | output | 32 | Remainder of the divide or of the root |

## Verification
Single isolated divides with small and large operands confirm the quotient digits and the latency. A zero divisor separates the saturating result from a plain digit error. Square roots of zero, of a perfect square and of the all-ones radicand confirm the root bits and the remainder bound. A square root followed five cycles later by a divide makes both slots finish on the same edge, which tests the slot-0-first ordering. Issues held high while both slots are full show that blocked requests are dropped. A long stream of pseudo-random mixed operations with gaps checks slot reuse and tag return, compared cycle by cycle against a behavioural model.

// File: rtl/divSqrtPkg.sv
package divSqrtPkg;

  localparam int NUM_SLOTS = 2;

  typedef enum logic {
    OP_DIV  = 1'b0,
    OP_SQRT = 1'b1
  } opKind_e;

  // strobes from the slot controller to one iteration engine
  typedef struct packed {
    logic load;    // capture operands, clear working state
    logic step;    // one radix-4 divide step or one root digit
    logic finish;  // copy working registers into the result registers
  } slotStrobe_t;

endpackage

// File: rtl/divSqrtEngine.sv
module divSqrtEngine
  import divSqrtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       strobe,
  input  logic              inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [TAG_W-1:0]  inTag,
  output logic [DATA_W-1:0] resQuo,
  output logic [DATA_W-1:0] resRem,
  output logic [TAG_W-1:0]  resTag
);

  localparam int WIDE_W = DATA_W + 2;

  logic              isSqrtR;
  logic [TAG_W-1:0]  tagR;
  logic [DATA_W-1:0] remR;
  logic [DATA_W-1:0] quoR;
  logic [DATA_W-1:0] numR;
  logic [DATA_W-1:0] denR;
  logic [DATA_W-1:0] resQuoR;
  logic [DATA_W-1:0] resRemR;

  logic [WIDE_W-1:0] remShift;
  logic [WIDE_W-1:0] denX1;
  logic [WIDE_W-1:0] denX2;
  logic [WIDE_W-1:0] denX3;
  logic [WIDE_W-1:0] sqrtTrial;
  logic [WIDE_W-1:0] nextRem;
  logic [DATA_W-1:0] nextQuo;

  // one iteration: bring down two numerator bits, then subtract the
  // largest multiple that fits (divide) or the trial 4r+1 (root)
  always_comb begin
    remShift  = {remR, numR[DATA_W-1 -: 2]};
    denX1     = {2'b00, denR};
    denX2     = denX1 << 1;
    denX3     = denX1 + denX2;
    sqrtTrial = {quoR, 2'b01};
    if (isSqrtR) begin
      if (remShift >= sqrtTrial) begin
        nextRem = remShift - sqrtTrial;
        nextQuo = {quoR[DATA_W-2:0], 1'b1};
      end else begin
        nextRem = remShift;
        nextQuo = {quoR[DATA_W-2:0], 1'b0};
      end
    end else if (remShift >= denX3) begin
      nextRem = remShift - denX3;
      nextQuo = {quoR[DATA_W-3:0], 2'd3};
    end else if (remShift >= denX2) begin
      nextRem = remShift - denX2;
      nextQuo = {quoR[DATA_W-3:0], 2'd2};
    end else if (remShift >= denX1) begin
      nextRem = remShift - denX1;
      nextQuo = {quoR[DATA_W-3:0], 2'd1};
    end else begin
      nextRem = remShift;
      nextQuo = {quoR[DATA_W-3:0], 2'd0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isSqrtR <= 1'b0;
      tagR    <= '0;
      remR    <= '0;
      quoR    <= '0;
      numR    <= '0;
      denR    <= '0;
      resQuoR <= '0;
      resRemR <= '0;
    end else begin
      if (strobe.load) begin
        isSqrtR <= inOp;
        tagR    <= inTag;
        numR    <= inA;
        denR    <= (inOp == OP_SQRT) ? '0 : inB;
        remR    <= '0;
        quoR    <= '0;
      end else if (strobe.step) begin
        remR <= nextRem[DATA_W-1:0];
        quoR <= nextQuo;
        numR <= numR << 2;
      end
      if (strobe.finish) begin
        resQuoR <= quoR;
        resRemR <= remR;
      end
    end
  end

  assign resQuo = resQuoR;
  assign resRem = resRemR;
  assign resTag = tagR;

  // the partial remainder never outgrows the data width
  p_rem_fits_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (nextRem[WIDE_W-1:DATA_W] == 2'b00));

  p_div_rem_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !isSqrtR && denR != '0) |=> (resRemR < denR));

  p_div_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !isSqrtR && denR == '0) |=> (resQuoR == '1));

  p_sqrt_rem_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && isSqrtR) |=>
      ((resQuoR >> (DATA_W/2)) == '0 && {1'b0, resRemR} <= {resQuoR, 1'b0}));

  p_tag_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(tagR));

endmodule

// File: rtl/divSqrtCtrl.sv
module divSqrtCtrl
  import divSqrtPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SQRT_PAD  = 5,
  localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          issueValid,
  input  logic                          issueOp,
  output slotStrobe_t [NUM_SLOTS-1:0]   strobes,
  output logic                          issueReady,
  output logic                          doneValid,
  output logic [SEL_W-1:0]              doneSel
);

  localparam int STEPS    = DATA_W / 2;
  localparam int DIV_LAT  = STEPS + 2;
  localparam int SQRT_LAT = STEPS + 2 + SQRT_PAD;
  localparam int CNT_W    = $clog2(SQRT_LAT);

  logic [NUM_SLOTS-1:0] busyV;
  logic [NUM_SLOTS-1:0] doneV;
  logic [NUM_SLOTS-1:0] freeV;
  logic [NUM_SLOTS-1:0] grantV;
  logic [NUM_SLOTS-1:0] loadV;
  logic [NUM_SLOTS-1:0] reportV;
  logic                 accept;

  function automatic logic [CNT_W-1:0] startCnt(input logic isSqrt);
    return isSqrt ? CNT_W'(SQRT_LAT - 1) : CNT_W'(DIV_LAT - 1);
  endfunction

  function automatic logic [CNT_W-1:0] stepFloor(input logic isSqrt);
    return isSqrt ? CNT_W'(SQRT_LAT - STEPS) : CNT_W'(DIV_LAT - STEPS);
  endfunction

  assign freeV      = ~(busyV | doneV);
  assign issueReady = |freeV;
  assign accept     = issueValid && issueReady;
  assign loadV      = accept ? grantV : '0;
  assign doneValid  = |doneV;

  // lowest free slot takes the issue; lowest finished slot reports
  always_comb begin
    logic gotFree;
    logic gotDone;
    grantV  = '0;
    reportV = '0;
    doneSel = '0;
    gotFree = 1'b0;
    gotDone = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (freeV[i] && !gotFree) begin
        grantV[i] = 1'b1;
        gotFree   = 1'b1;
      end
      if (doneV[i] && !gotDone) begin
        reportV[i] = 1'b1;
        doneSel    = SEL_W'(i);
        gotDone    = 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : gSlot
    logic             busy;
    logic             done;
    logic             isSqrt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   age;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy   <= 1'b0;
        done   <= 1'b0;
        isSqrt <= 1'b0;
        cnt    <= '0;
      end else begin
        if (loadV[gi]) begin
          busy   <= 1'b1;
          isSqrt <= issueOp;
          cnt    <= startCnt(issueOp);
        end else if (busy) begin
          if (cnt == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (reportV[gi]) done <= 1'b0;
      end
    end

    assign busyV[gi]          = busy;
    assign doneV[gi]          = done;
    assign strobes[gi].load   = loadV[gi];
    assign strobes[gi].step   = busy && (cnt >= stepFloor(isSqrt));
    assign strobes[gi].finish = busy && (cnt == '0);

    // independent age count since the operation was taken
    always_ff @(posedge clk) begin
      if (!rstN)             age <= '0;
      else if (loadV[gi])    age <= '0;
      else if (busy)         age <= age + 1'b1;
    end

    p_latency_r4_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(done) |-> (age == (isSqrt ? (CNT_W+1)'(SQRT_LAT) : (CNT_W+1)'(DIV_LAT))));
  end

  p_one_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadV));

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (&(busyV | doneV)) |-> !issueReady);

  p_report_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneV[0] && doneV[1]) |=> (doneValid && doneV[1] && !doneV[0] && doneSel == SEL_W'(1)));

endmodule

// File: rtl/divSqrtPair.sv
module divSqrtPair
  import divSqrtPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int SQRT_PAD = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueOp,
  input  logic [DATA_W-1:0] issueA,
  input  logic [DATA_W-1:0] issueB,
  input  logic [TAG_W-1:0]  issueTag,
  output logic              issueReady,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic [DATA_W-1:0] doneQuo,
  output logic [DATA_W-1:0] doneRem
);

  localparam int SEL_W = $clog2(NUM_SLOTS);

  slotStrobe_t [NUM_SLOTS-1:0] strobes;
  logic [SEL_W-1:0]            doneSel;
  logic [DATA_W-1:0]           slotQuo [NUM_SLOTS];
  logic [DATA_W-1:0]           slotRem [NUM_SLOTS];
  logic [TAG_W-1:0]            slotTag [NUM_SLOTS];

  divSqrtCtrl #(
    .DATA_W   (DATA_W),
    .SQRT_PAD (SQRT_PAD)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .strobes    (strobes),
    .issueReady (issueReady),
    .doneValid  (doneValid),
    .doneSel    (doneSel)
  );

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : gEng
    divSqrtEngine #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) uEng (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[gi]),
      .inOp   (issueOp),
      .inA    (issueA),
      .inB    (issueB),
      .inTag  (issueTag),
      .resQuo (slotQuo[gi]),
      .resRem (slotRem[gi]),
      .resTag (slotTag[gi])
    );
  end

  assign doneQuo = slotQuo[doneSel];
  assign doneRem = slotRem[doneSel];
  assign doneTag = slotTag[doneSel];

endmodule

// File: tb/sim_divSqrtPair.sv
`timescale 1ns/1ps
module sim_divSqrtPair;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueOp = 1'b0;
  logic [31:0] issueA = '0;
  logic [31:0] issueB = '0;
  logic [3:0]  issueTag = '0;
  logic        issueReady;
  logic        doneValid;
  logic [3:0]  doneTag;
  logic [31:0] doneQuo;
  logic [31:0] doneRem;

  int nCmp = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  divSqrtPair u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueA(issueA), .issueB(issueB), .issueTag(issueTag),
    .issueReady(issueReady), .doneValid(doneValid), .doneTag(doneTag),
    .doneQuo(doneQuo), .doneRem(doneRem)
  );

  // behavioural model: two slots, each a countdown plus a held result
  bit          mBusy [2];
  bit          mDone [2];
  int          mCnt  [2];
  logic [31:0] mQ    [2];
  logic [31:0] mR    [2];
  logic [3:0]  mTag  [2];
  string       mReq  [2];
  bit          fr0, fr1;
  int          slot;

  function automatic logic [31:0] rootOf(input logic [31:0] a);
    longint r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= longint'(a)) r = t;
    end
    return r[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin mBusy[i] = 0; mDone[i] = 0; mCnt[i] = 0; end
    end else begin
      fr0 = !mBusy[0] && !mDone[0];
      fr1 = !mBusy[1] && !mDone[1];
      if (mDone[0]) mDone[0] = 0;
      else if (mDone[1]) mDone[1] = 0;
      for (int i = 0; i < 2; i++) begin
        if (mBusy[i]) begin
          mCnt[i]--;
          if (mCnt[i] == 0) begin mBusy[i] = 0; mDone[i] = 1; end
        end
      end
      if (issueValid && (fr0 || fr1)) begin
        slot = fr0 ? 0 : 1;
        mBusy[slot] = 1;
        mTag[slot]  = issueTag;
        if (issueOp) begin
          mCnt[slot] = 23;
          mQ[slot]   = rootOf(issueA);
          mR[slot]   = issueA - mQ[slot] * mQ[slot];
          mReq[slot] = "R3";
        end else begin
          mCnt[slot] = 18;
          if (issueB == 0) begin
            mQ[slot] = 32'hFFFF_FFFF; mR[slot] = issueA; mReq[slot] = "R2";
          end else begin
            mQ[slot] = issueA / issueB; mR[slot] = issueA % issueB; mReq[slot] = "R1";
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      check(doneValid == 1'b0, "R10", "doneValid in reset", 32'(doneValid), 0);
      check(issueReady == 1'b1, "R10", "issueReady in reset", 32'(issueReady), 1);
    end else begin
      automatic bit expV   = mDone[0] || mDone[1];
      automatic int sel    = mDone[0] ? 0 : 1;
      automatic bit expRdy = !((mBusy[0] || mDone[0]) && (mBusy[1] || mDone[1]));
      check(issueReady == expRdy, "R6", "issueReady", 32'(issueReady), 32'(expRdy));
      check(doneValid == expV, "R4 R5 R7 R8 R11", "doneValid", 32'(doneValid), 32'(expV));
      if (expV && doneValid) begin
        check(doneTag == mTag[sel], "R9", "doneTag", 32'(doneTag), 32'(mTag[sel]));
        check(doneQuo == mQ[sel], mReq[sel], "doneQuo", doneQuo, mQ[sel]);
        check(doneRem == mR[sel], mReq[sel], "doneRem", doneRem, mR[sel]);
      end
    end
  end

  task automatic issue(input logic op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] tag);
    issueValid = 1'b1; issueOp = op; issueA = a; issueB = b; issueTag = tag;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    idle(4);
    rstN = 1'b1;
    idle(2);
    // R1 R4: isolated divides
    issue(1'b0, 32'd100, 32'd7, 4'h1);        idle(22);
    issue(1'b0, 32'hFFFF_FFFF, 32'd3, 4'h2);  idle(22);
    issue(1'b0, 32'd5, 32'hFFFF_FFF0, 4'h3);  idle(22);
    // R2: zero divisor
    issue(1'b0, 32'd12345, 32'd0, 4'h4);      idle(22);
    // R3 R5: roots
    issue(1'b1, 32'd1000000, 32'd0, 4'h5);    idle(26);
    issue(1'b1, 32'hFFFF_FFFF, 32'd0, 4'h6);  idle(26);
    issue(1'b1, 32'd0, 32'd0, 4'h7);          idle(26);
    // R8: root in slot 0, divide in slot 1, both finish on one edge
    issue(1'b1, 32'd99999, 32'd0, 4'h8);
    idle(4);
    issue(1'b0, 32'd99999, 32'd10, 4'h9);     idle(30);
    // R6 R11: valid held for four cycles, two are blocked
    issue(1'b0, 32'd81, 32'd9, 4'hA);
    issue(1'b1, 32'd81, 32'd0, 4'hB);
    issue(1'b0, 32'd7, 32'd2, 4'hC);
    issue(1'b1, 32'd50, 32'd0, 4'hD);         idle(30);
    // R7: slot 0 reused while slot 1 busy, then a same-edge finish
    issue(1'b0, 32'd1000, 32'd33, 4'hE);
    idle(14);
    issue(1'b1, 32'd4096, 32'd0, 4'hF);
    idle(4);
    issue(1'b0, 32'd77, 32'd0, 4'h0);         idle(30);
    // mixed stream
    for (int k = 0; k < 120; k++) begin
      logic [31:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed >> (seed[4:0]);
      issue(seed[7], a, (seed[12:9] == 0) ? 32'd0 : b, seed[19:16]);
      if (seed[22]) idle(int'(seed[27:24]));
    end
    idle(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule